// File: doc/BRIEF.md
# DMA Descriptor Linking Engine

This block keeps a small parameter memory of transfer descriptors. Each descriptor is eight 32-bit words, or 32 bytes. One slot is the live descriptor of a single DMA channel. Each synchronization event steps that live descriptor. The count fields go down by one and the source and destination addresses move by signed strides. When the last count runs out, the block raises a completion pulse carrying a code, provided the descriptor asks for one. In the same cycle it rewrites the live descriptor from the slot named by its link field, or it blanks the live descriptor when the link is null.

Software fills the descriptors through a simple word-wide write/read port and then leaves the engine alone. Two descriptors that point at each other form a ping-pong chain that reloads itself indefinitely. The block moves no data and does not master a bus. It only keeps the address and count bookkeeping that a transfer engine would consume.

Top module: `dma_link_engine`

## Requirements
- R1: A write on the host port stores `hostWdata` at word address `hostAddr` = slot*8 + word. `hostRdata` shows the addressed word combinationally. The words of a slot are laid out as follows:
  - word 0: options
  - word 1: source address
  - word 2: counts, with the first-dimension count in bits 15:0 and BCNT in bits 31:16
  - word 3: destination address
  - word 4: B strides, with the source stride in bits 15:0 and the destination stride in bits 31:16
  - word 5: link word, with the link in bits 15:0 and the BCNT reload value in bits 31:16
  - word 6: C strides, with the source stride low and the destination stride high
  - word 7: CCNT in bits 15:0
- R2: When an event arrives and BCNT > 1, the live slot updates as follows on the next clock edge:
  - BCNT drops by one.
  - The source address grows by the sign-extended source B stride.
  - The destination address grows by the sign-extended destination B stride.
- R3: When an event arrives with BCNT = 1 and CCNT > 1, the live slot updates as follows:
  - BCNT is reloaded from the reload value.
  - CCNT drops by one.
  - The addresses move by the sign-extended C strides instead of the B strides.
- R4: An event with BCNT = 1 and CCNT = 1 is the final event. If options bit 20 is set, the final event raises `doneStrobe` for exactly one cycle after its clock edge, with `doneCode` = options bits 17:12. If bit 20 is clear, the strobe stays low.
- R5: On the final event with a valid, in-range link, all eight words of the target slot are copied into the live slot.
- R6: On the final event with link FFFFh, every live word is cleared to zero except word 5, which becomes 0000FFFFh.
- R7: When the link is decoded, bits 15:14 and bits 4:0 are ignored, and the target slot is link bits 13:5.
- R8: If the decoded target slot is not below the slot count, the final event pulses `linkErr` for one cycle and leaves the live slot unchanged. Completion is still signalled as in R4.
- R9: An event while BCNT or CCNT of the live slot is zero has no effect on the memory or on the outputs.
- R10: Two slots that link to each other keep reloading the live slot alternately without any host writes.
- R11: After reset, `doneStrobe`, `doneCode` and `linkErr` are low. The memory contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the control outputs |
| hostWe | input | 1 | Host word write strobe |
| hostAddr | input | 6 | Host word address (slot*8 + word) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Word at `hostAddr` |
| evt | input | 1 | Synchronization event, one cycle per event |
| doneStrobe | output | 1 | One-cycle completion pulse |
| doneCode | output | 6 | Completion code, valid while `doneStrobe` is high |
| linkErr | output | 1 | One-cycle out-of-range link flag |

## Verification
A wrong count or stride update shows up on the very next host read of the live slot's address words. A wrong count also moves the completion pulse to the wrong event, so the pulse comes early or late in a sweep where every event is checked. A wrong link decode or copy is visible in the first read after the final event, because the bench compares all eight live words against the target slot. In the ping-pong chain, an error compounds in later rounds as wrong completion codes and wrong restart addresses. A stuck or wrongly gated strobe shows within one cycle of the event that should or should not raise it.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

  localparam int W_OPT  = 0;
  localparam int W_SRC  = 1;
  localparam int W_CNT  = 2;
  localparam int W_DST  = 3;
  localparam int W_BIDX = 4;
  localparam int W_LINK = 5;
  localparam int W_CIDX = 6;
  localparam int W_CCNT = 7;

  localparam logic [15:0] NULL_LINK = 16'hFFFF;

  typedef struct packed {
    logic       stepB;
    logic       stepC;
    logic       linkCopy;
    logic       nullClear;
    logic       linkErr;
    logic [8:0] linkIdx;
  } dlink_strobe_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

endpackage

// File: rtl/dlink_ctrl.sv
module dlink_ctrl
  import dlink_pkg::*;
#(
  parameter int DESC_NUM = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          evt,
  input  logic [31:0]   optWord,
  input  logic [31:0]   cntWord,
  input  logic [31:0]   linkWord,
  input  logic [31:0]   ccntWord,
  output dlink_strobe_t ctl,
  output logic          doneStrobe,
  output logic [5:0]    doneCode,
  output logic          linkErr
);

  localparam logic [9:0] SLOT_LIMIT = 10'(DESC_NUM);

  logic [15:0] bcnt;
  logic [15:0] ccnt;
  logic [15:0] link;
  logic        idle;
  logic        finish;
  logic        inRange;
  logic        irqEn;

  assign bcnt    = cntWord[31:16];
  assign ccnt    = ccntWord[15:0];
  assign link    = linkWord[15:0];
  assign idle    = (bcnt == 16'd0) || (ccnt == 16'd0);
  assign inRange = {1'b0, link[13:5]} < SLOT_LIMIT;
  assign irqEn   = optWord[20];
  assign finish  = evt && !idle && (bcnt == 16'd1) && (ccnt == 16'd1);

  always_comb begin
    ctl         = '0;
    ctl.linkIdx = link[13:5];
    if (evt && !idle) begin
      if (bcnt != 16'd1) begin
        ctl.stepB = 1'b1;
      end else if (ccnt != 16'd1) begin
        ctl.stepC = 1'b1;
      end else if (link == NULL_LINK) begin
        ctl.nullClear = 1'b1;
      end else if (!inRange) begin
        ctl.linkErr = 1'b1;
      end else begin
        ctl.linkCopy = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStrobe <= 1'b0;
      doneCode   <= '0;
      linkErr    <= 1'b0;
    end else begin
      doneStrobe <= finish && irqEn;
      doneCode   <= (finish && irqEn) ? optWord[17:12] : 6'd0;
      linkErr    <= ctl.linkErr;
    end
  end

  logic unusedBits;
  assign unusedBits = ^{optWord[31:21], optWord[19:18], optWord[11:0],
                        cntWord[15:0], linkWord[31:16], ccntWord[31:16]};

  AST_DONE_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> $past(evt)); // R4

  AST_ERR_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    linkErr |-> $past(evt)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (evt && idle) |=> (!doneStrobe && !linkErr)); // R9

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.stepB, ctl.stepC, ctl.linkCopy, ctl.nullClear, ctl.linkErr})); // R3

endmodule

// File: rtl/dlink_dpath.sv
module dlink_dpath
  import dlink_pkg::*;
#(
  parameter int DESC_NUM    = 8,
  parameter int ACTIVE_SLOT = 0,
  localparam int IDXW       = $clog2(DESC_NUM),
  localparam int AW         = IDXW + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [AW-1:0]     hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  input  dlink_strobe_t     ctl,
  output logic [7:0][31:0]  actWords
);

  localparam int WORDS = DESC_NUM * 8;
  localparam logic [IDXW-1:0] ACT_IDX = IDXW'(ACTIVE_SLOT);

  logic [31:0] mem [WORDS];
  logic [IDXW-1:0] srcIdx;
  logic hostHitsActive;

  assign srcIdx         = ctl.linkIdx[IDXW-1:0];
  assign hostRdata      = mem[hostAddr];
  assign hostHitsActive = hostWe && (hostAddr[AW-1:3] == ACT_IDX);

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      actWords[k] = mem[{ACT_IDX, 3'(k)}];
    end
  end

  always_ff @(posedge clk) begin
    if (hostWe) begin
      mem[hostAddr] <= hostWdata;
    end
    if (ctl.stepB) begin
      mem[{ACT_IDX, 3'(W_CNT)}][31:16] <= actWords[W_CNT][31:16] - 16'd1;
      mem[{ACT_IDX, 3'(W_SRC)}] <= actWords[W_SRC] + sext16(actWords[W_BIDX][15:0]);
      mem[{ACT_IDX, 3'(W_DST)}] <= actWords[W_DST] + sext16(actWords[W_BIDX][31:16]);
    end
    if (ctl.stepC) begin
      mem[{ACT_IDX, 3'(W_CNT)}][31:16] <= actWords[W_LINK][31:16];
      mem[{ACT_IDX, 3'(W_CCNT)}][15:0] <= actWords[W_CCNT][15:0] - 16'd1;
      mem[{ACT_IDX, 3'(W_SRC)}] <= actWords[W_SRC] + sext16(actWords[W_CIDX][15:0]);
      mem[{ACT_IDX, 3'(W_DST)}] <= actWords[W_DST] + sext16(actWords[W_CIDX][31:16]);
    end
    if (ctl.linkCopy) begin
      for (int k = 0; k < 8; k++) begin
        mem[{ACT_IDX, 3'(k)}] <= mem[{srcIdx, 3'(k)}];
      end
    end
    if (ctl.nullClear) begin
      for (int k = 0; k < 8; k++) begin
        mem[{ACT_IDX, 3'(k)}] <= (k == W_LINK) ? {16'd0, NULL_LINK} : 32'd0;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^ctl.linkIdx;

  AST_BCNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepB |=> actWords[W_CNT][31:16] == $past(actWords[W_CNT][31:16]) - 16'd1); // R2

  AST_CCNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepC && !hostHitsActive) |=>
      actWords[W_CCNT][15:0] == $past(actWords[W_CCNT][15:0]) - 16'd1); // R3

  AST_NULL_FILL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nullClear |=> (actWords[W_LINK] == 32'h0000FFFF && actWords[W_CNT] == 32'd0
                       && actWords[W_CCNT] == 32'd0)); // R6

  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.linkErr && !hostHitsActive) |=> $stable(actWords)); // R8

endmodule

// File: rtl/dma_link_engine.sv
module dma_link_engine
  import dlink_pkg::*;
#(
  parameter int DESC_NUM    = 8,
  parameter int ACTIVE_SLOT = 0,
  localparam int AW         = $clog2(DESC_NUM) + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [31:0]   hostWdata,
  output logic [31:0]   hostRdata,
  input  logic          evt,
  output logic          doneStrobe,
  output logic [5:0]    doneCode,
  output logic          linkErr
);

  dlink_strobe_t     ctl;
  logic [7:0][31:0]  actWords;

  dlink_ctrl #(.DESC_NUM(DESC_NUM)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .optWord    (actWords[W_OPT]),
    .cntWord    (actWords[W_CNT]),
    .linkWord   (actWords[W_LINK]),
    .ccntWord   (actWords[W_CCNT]),
    .ctl        (ctl),
    .doneStrobe (doneStrobe),
    .doneCode   (doneCode),
    .linkErr    (linkErr)
  );

  dlink_dpath #(.DESC_NUM(DESC_NUM), .ACTIVE_SLOT(ACTIVE_SLOT)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .ctl       (ctl),
    .actWords  (actWords)
  );

endmodule

// File: tb/tb_dma_link_engine.sv
module tb_dma_link_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        evt = 1'b0;
  logic        doneStrobe;
  logic [5:0]  doneCode;
  logic        linkErr;

  int total = 0;
  int bad = 0;
  logic [31:0] shadow [64];
  logic        sDone, sErr;
  logic [5:0]  sCode;

  always #2 clk = ~clk;

  dma_link_engine dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .evt(evt),
    .doneStrobe(doneStrobe), .doneCode(doneCode), .linkErr(linkErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 6'(addr); hostWdata = data;
    @(negedge clk);
    hostWe = 1'b0;
    shadow[addr] = data;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    hostAddr = 6'(addr);
    #1 data = hostRdata;
  endtask

  task automatic fire();
    @(negedge clk);
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
    sDone = doneStrobe; sCode = doneCode; sErr = linkErr;
  endtask

  function automatic logic [7:0][31:0] mk(
      input logic [31:0] opt, input logic [31:0] src, input logic [15:0] b,
      input logic [31:0] dst, input logic [15:0] sbi, input logic [15:0] dbi,
      input logic [15:0] link, input logic [15:0] rld, input logic [15:0] sci,
      input logic [15:0] dci, input logic [15:0] c);
    logic [7:0][31:0] d;
    d[0] = opt; d[1] = src; d[2] = {b, 16'h0040}; d[3] = dst;
    d[4] = {dbi, sbi}; d[5] = {rld, link}; d[6] = {dci, sci}; d[7] = {16'd0, c};
    return d;
  endfunction

  task automatic load(input int slot, input logic [7:0][31:0] d);
    for (int k = 0; k < 8; k++) wr(slot * 8 + k, d[k]);
  endtask

  task automatic expectSlot(input string tag, input logic [7:0][31:0] exp);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(k, v);
      chk(tag, v, exp[k]);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [7:0][31:0] slotOf(input int s);
    logic [7:0][31:0] d;
    for (int k = 0; k < 8; k++) d[k] = shadow[s * 8 + k];
    return d;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, s, dd, srcExp;
    logic [7:0][31:0] d;
    logic [15:0] b, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 doneStrobe after reset", 32'(doneStrobe), 0);
    chk("R11 doneCode after reset", 32'(doneCode), 0);
    chk("R11 linkErr after reset", 32'(linkErr), 0);

    for (int sl = 1; sl < 8; sl++)
      load(sl, mk(32'(sl) << 12, 32'h4000_0000 + 32'(sl), 16'(sl + 1), 32'h5000_0000 + 32'(sl),
                  16'(sl), 16'(sl * 2), 16'h00E0, 16'(sl), 16'(sl * 3), 16'hFFF0, 16'(sl)));
    for (int k = 0; k < 8; k++) begin
      rd(6 * 8 + k, v);
      chk("R1 readback slot6", v, shadow[48 + k]);
    end
    wr(7, 32'hA5A5_0003);
    rd(7, v);
    chk("R1 readback word7", v, 32'hA5A5_0003);

    for (int bc = 1; bc <= 3; bc++) begin
      for (int cc = 1; cc <= 3; cc++) begin
        int t = 1 + ((bc * 3 + cc) % 7);
        int ien = (bc + cc) % 2;
        logic [5:0] code = 6'(bc * 8 + cc);
        logic [15:0] sbi = 16'(bc * 2);
        logic [15:0] dbi = 16'(-(cc * 3));
        logic [15:0] sci = 16'hFFF0;
        logic [15:0] dci = 16'd40;
        d = mk((32'(ien) << 20) | (32'(code) << 12), 32'h0001_0000 * 32'(bc), 16'(bc),
               32'h8000_0000, sbi, dbi, 16'(t * 32), 16'(bc), sci, dci, 16'(cc));
        load(0, d);
        s = d[1]; dd = d[3]; b = 16'(bc); c = 16'(cc);
        for (int e = 1; e <= bc * cc; e++) begin
          fire();
          if (e < bc * cc) begin
            string tg;
            if (b > 1) begin
              b = b - 1; s = s + sx(sbi); dd = dd + sx(dbi); tg = "R2";
            end else begin
              b = 16'(bc); c = c - 1; s = s + sx(sci); dd = dd + sx(dci); tg = "R3";
            end
            chk({tg, " no strobe mid-transfer"}, 32'(sDone), 0);
            rd(2, v); chk({tg, " BCNT"}, 32'(v[31:16]), 32'(b));
            rd(7, v); chk({tg, " CCNT"}, 32'(v[15:0]), 32'(c));
            rd(1, v); chk({tg, " source address"}, v, s);
            rd(3, v); chk({tg, " destination address"}, v, dd);
          end else begin
            chk("R4 completion strobe gated by enable", 32'(sDone), 32'(ien));
            chk("R4 completion code", 32'(sCode), ien != 0 ? 32'(code) : 0);
            chk("R8 no link error on valid link", 32'(sErr), 0);
            expectSlot("R5 link copy", slotOf(t));
          end
        end
      end
    end

    load(0, mk(32'h0013_F000, 32'h1111, 16'd1, 32'h2222, 16'd4, 16'd4,
               16'hFFFF, 16'd3, 16'd1, 16'd1, 16'd1));
    fire();
    chk("R4 strobe on null-link final", 32'(sDone), 1);
    chk("R4 code on null-link final", 32'(sCode), 32'h3F);
    for (int k = 0; k < 8; k++) d[k] = (k == 5) ? 32'h0000FFFF : 32'd0;
    expectSlot("R6 null clear", d);
    fire();
    chk("R9 no strobe on idle slot", 32'(sDone), 0);
    chk("R9 no error on idle slot", 32'(sErr), 0);
    expectSlot("R9 idle slot unchanged", d);
    d = mk(32'h0010_1000, 32'h7777, 16'd0, 32'h8888, 16'd4, 16'd4,
           16'h0020, 16'd2, 16'd1, 16'd1, 16'd2);
    load(0, d);
    fire();
    chk("R9 zero BCNT no strobe", 32'(sDone), 0);
    expectSlot("R9 zero BCNT unchanged", d);

    load(0, mk(32'h0010_2000, 32'h1, 16'd1, 32'h2, 16'd1, 16'd1,
               16'h4040, 16'd1, 16'd1, 16'd1, 16'd1));
    fire();
    expectSlot("R7 upper link bits ignored", slotOf(2));
    load(0, mk(32'h0010_2000, 32'h1, 16'd1, 32'h2, 16'd1, 16'd1,
               16'hC065, 16'd1, 16'd1, 16'd1, 16'd1));
    fire();
    expectSlot("R7 low link bits ignored", slotOf(3));

    d = mk(32'h0011_1000, 32'h3333, 16'd1, 32'h4444, 16'd2, 16'd2,
           16'h0100, 16'd1, 16'd1, 16'd1, 16'd1);
    load(0, d);
    fire();
    chk("R8 link error raised", 32'(sErr), 1);
    chk("R8 completion still raised", 32'(sDone), 1);
    chk("R8 completion code", 32'(sCode), 32'h11);
    expectSlot("R8 slot unchanged", d);
    @(negedge clk);
    chk("R8 link error lasts one cycle", 32'(linkErr), 0);
    d = mk(32'h0001_1000, 32'h3333, 16'd1, 32'h4444, 16'd2, 16'd2,
           16'h3FE0, 16'd1, 16'd1, 16'd1, 16'd1);
    load(0, d);
    fire();
    chk("R8 far link error", 32'(sErr), 1);
    chk("R4 no strobe when disabled", 32'(sDone), 0);
    expectSlot("R8 far link slot unchanged", d);

    load(4, mk(32'h0010_5000, 32'h1000, 16'd2, 32'h9000, 16'd4, 16'd4,
               16'h00A0, 16'd2, 16'd0, 16'd0, 16'd1));
    load(5, mk(32'h0010_9000, 32'h2000, 16'd1, 32'hA000, 16'd0, 16'd0,
               16'h0080, 16'd1, 16'd8, 16'd8, 16'd2));
    load(0, slotOf(4));
    for (int r = 0; r < 6; r++) begin
      fire();
      chk("R10 first event of round no strobe", 32'(sDone), 0);
      fire();
      chk("R10 round completion", 32'(sDone), 1);
      chk("R10 alternating code", 32'(sCode), (r % 2 == 0) ? 32'd5 : 32'd9);
      srcExp = (r % 2 == 0) ? 32'h2000 : 32'h1000;
      rd(1, v);
      chk("R10 restart source", v, srcExp);
    end

    finish_run();
  end

endmodule